// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer. A shared timebase supplies the running counter value, a count-enable strobe, the count direction and an update-event pulse. From these inputs and a programmed compare value, the channel produces a single reference level. Downstream logic, such as polarity or dead-time stages, turns that level into a pin.

Software writes two things. The first is the compare value. The second is a 16-bit control word that holds the settings of two channels side by side. A parameter selects which half of the word this instance decodes. Each half holds five fields: an external-clear enable, a 3-bit compare behaviour, a compare preload enable, a fast-path enable and a 2-bit direction select.

The compare value can be double-buffered. With preload on, a new value only takes effect at an update event, so a PWM period is never cut short by a mid-period write. An external clear input can pull the reference low until the next update event.

Top module: `oc_channel`

## Requirements
- R1: After reset the output is low and the control word is zero, so the channel is an output in frozen behaviour with preload, fast path and clear disabled.
- R2: With HI_HALF=0 the channel decodes control bits 7 (clear enable), 6:4 (behaviour), 3 (preload), 2 (fast) and 1:0 (direction select). With HI_HALF=1 it decodes bits 15, 14:12, 11, 10 and 9:8 in the same order. The half it does not decode has no effect on the output.
- R3: Behaviour code 1 drives the reference high on a match, and code 2 drives it low on a match. A match is a cycle in which the count enable is high and the counter equals the active compare value.
- R4: Behaviour code 3 inverts the reference once per match cycle. A counter equal to the compare value while the count enable is low does not toggle it.
- R5: Code 4 forces the reference low and code 5 forces it high. Code 0 (frozen) holds the last reference level even when a match occurs.
- R6: Code 6 while counting up (direction input 0) gives high when counter < compare, else low. While counting down (direction input 1) it gives low when counter > compare, else high.
- R7: Code 7 gives the inverse of code 6 for the same counter, compare value and direction.
- R8: With preload off, a compare write becomes the active compare value on the next cycle. With preload on, the write goes to a shadow register only, and the shadow is copied to the active value on each update-event pulse.
- R9: With the fast bit set, a counter value presented before a clock edge is reflected on the output right after that edge. With the fast bit clear, it is reflected two cycles later, after the third edge.
- R10: With clear enable set, a high level on the external clear input forces the reference low. The reference stays low after the input falls, until an update event. With clear enable off, the input has no effect.
- R11: When the direction select is non-zero (the channel is not an output), the reference is held low whatever the behaviour code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Timebase counter value |
| cnt_en_i | input | 1 | Counter advanced this cycle; qualifies matches |
| dir_down_i | input | 1 | 1 while the timebase counts down |
| upd_i | input | 1 | Update-event pulse |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 16 | Control word write data |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value write data |
| ext_clr_i | input | 1 | External clear request |
| oc_ref_o | output | 1 | Output reference level |

## Verification
Most internal faults here become visible at the output within a few cycles. A wrong active compare value shifts the PWM edge or the match point, so it is exposed as soon as the counter crosses the expected threshold. A shadow register copied at the wrong time shows as a duty-cycle change before or after the update pulse. A stuck clear-hold flag keeps the output low past an update event. A mis-selected control half makes a write to the other channel's bits change this output. Since the slow path adds two cycles, every latency check samples at the exact edge where the level must first change, with one cycle of margin on neither side.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int CTL_W  = 16;
    localparam int HALF_W = CTL_W / 2;

    typedef enum logic [2:0] {
        OCM_FROZEN = 3'd0,
        OCM_SET    = 3'd1,
        OCM_CLR    = 3'd2,
        OCM_TOG    = 3'd3,
        OCM_LOW    = 3'd4,
        OCM_HIGH   = 3'd5,
        OCM_PWM_A  = 3'd6,
        OCM_PWM_B  = 3'd7
    } oc_mode_e;

    // Field order inside one half of the control word, MSB first.
    typedef struct packed {
        logic     clr_en;
        oc_mode_e mode;
        logic     preload;
        logic     fast;
        logic [1:0] sel;
    } oc_cfg_t;

endpackage

// File: rtl/oc_ctl_decode.sv
module oc_ctl_decode
    import oc_pkg::*;
#(
    parameter bit HI_HALF = 1'b0
) (
    input  logic [CTL_W-1:0] ctl,
    output oc_cfg_t          cfg
);
    generate
        if (HI_HALF) begin : g_hi
            assign cfg = oc_cfg_t'(ctl[CTL_W-1:HALF_W]);
        end else begin : g_lo
            assign cfg = oc_cfg_t'(ctl[HALF_W-1:0]);
        end
    endgenerate
endmodule

// File: rtl/oc_cmp_shadow.sv
module oc_cmp_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preload,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             upd,
    output logic [CNT_W-1:0] active,
    output logic [CNT_W-1:0] shadow
);
    typedef struct packed {
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] shadow;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.shadow = wdata;
        end
        if (preload) begin
            // The copy takes the shadow as it stood before this cycle's write.
            if (upd) begin
                st_d.active = st_q.shadow;
            end
        end else if (we) begin
            st_d.active = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign shadow = st_q.shadow;
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  oc_cfg_t          cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_en,
    input  logic             dir_down,
    input  logic [CNT_W-1:0] cmp,
    input  logic             upd,
    input  logic             ext_clr,
    output logic             ref_lvl
);
    typedef struct packed {
        logic lvl;
        logic clr_hold;
    } ref_st_t;

    ref_st_t st_d, st_q;
    logic    hit;
    logic    pwm_a;
    logic    clr_act;

    always_comb begin
        hit     = cnt_en && (cnt == cmp);
        pwm_a   = dir_down ? !(cnt > cmp) : (cnt < cmp);
        clr_act = cfg.clr_en && (st_q.clr_hold || ext_clr);

        st_d          = st_q;
        st_d.clr_hold = cfg.clr_en && (ext_clr || (st_q.clr_hold && !upd));

        if (cfg.sel != 2'd0) begin
            st_d.lvl = 1'b0;
        end else if (clr_act) begin
            st_d.lvl = 1'b0;
        end else begin
            unique case (cfg.mode)
                OCM_FROZEN: st_d.lvl = st_q.lvl;
                OCM_SET:    st_d.lvl = hit ? 1'b1 : st_q.lvl;
                OCM_CLR:    st_d.lvl = hit ? 1'b0 : st_q.lvl;
                OCM_TOG:    st_d.lvl = hit ? !st_q.lvl : st_q.lvl;
                OCM_LOW:    st_d.lvl = 1'b0;
                OCM_HIGH:   st_d.lvl = 1'b1;
                OCM_PWM_A:  st_d.lvl = pwm_a;
                OCM_PWM_B:  st_d.lvl = !pwm_a;
                default:    st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_lvl = st_q.lvl;
endmodule

// File: rtl/oc_out_delay.sv
module oc_out_delay #(
    parameter int SLOW_EXTRA = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    input  logic lvl_in,
    output logic lvl_out
);
    localparam int LAST = SLOW_EXTRA - 1;

    logic [SLOW_EXTRA-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = lvl_in;
        for (int i = 1; i < SLOW_EXTRA; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign lvl_out = fast ? lvl_in : pipe_q[LAST];
endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter bit HI_HALF    = 1'b0,
    parameter int SLOW_EXTRA = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_en_i,
    input  logic             dir_down_i,
    input  logic             upd_i,
    input  logic             ctl_we_i,
    input  logic [15:0]      ctl_wdata_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    input  logic             ext_clr_i,
    output logic             oc_ref_o
);
    logic [CTL_W-1:0] ctl_d, ctl_q;
    oc_cfg_t          cfg;
    logic [CNT_W-1:0] active_cmp;
    logic [CNT_W-1:0] shadow_cmp;
    logic             ref_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_we_i) begin
            ctl_d = ctl_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    oc_ctl_decode #(.HI_HALF(HI_HALF)) u_dec (
        .ctl (ctl_q),
        .cfg (cfg)
    );

    oc_cmp_shadow #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .preload (cfg.preload),
        .we      (cmp_we_i),
        .wdata   (cmp_wdata_i),
        .upd     (upd_i),
        .active  (active_cmp),
        .shadow  (shadow_cmp)
    );

    oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .cnt      (cnt_i),
        .cnt_en   (cnt_en_i),
        .dir_down (dir_down_i),
        .cmp      (active_cmp),
        .upd      (upd_i),
        .ext_clr  (ext_clr_i),
        .ref_lvl  (ref_q)
    );

    oc_out_delay #(.SLOW_EXTRA(SLOW_EXTRA)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast    (cfg.fast),
        .lvl_in  (ref_q),
        .lvl_out (oc_ref_o)
    );
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input oc_cfg_t          cfg,
    input logic [CNT_W-1:0] cnt_i,
    input logic             cnt_en_i,
    input logic             upd_i,
    input logic             cmp_we_i,
    input logic [CNT_W-1:0] cmp_wdata_i,
    input logic             ext_clr_i,
    input logic [CNT_W-1:0] active_cmp,
    input logic             ref_q
);
    p_sel_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel != 2'd0) |=> !ref_q);

    p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel == 2'd0 && cfg.mode == OCM_HIGH && !cfg.clr_en) |=> ref_q);

    p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == OCM_LOW) |=> !ref_q);

    p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel == 2'd0 && cfg.mode == OCM_FROZEN && !cfg.clr_en) |=> $stable(ref_q));

    p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel == 2'd0 && cfg.mode == OCM_TOG && !cfg.clr_en && cnt_en_i
         && cnt_i == active_cmp) |=> (ref_q != $past(ref_q)));

    p_preload_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.preload && !upd_i) |=> $stable(active_cmp));

    p_direct_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.preload && cmp_we_i) |=> (active_cmp == $past(cmp_wdata_i)));

    p_ext_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.clr_en && ext_clr_i) |=> !ref_q);
endmodule

bind oc_channel oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .cnt_i       (cnt_i),
    .cnt_en_i    (cnt_en_i),
    .upd_i       (upd_i),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .ext_clr_i   (ext_clr_i),
    .active_cmp  (active_cmp),
    .ref_q       (ref_q)
);

// File: tb/oc_channel_tb.sv
module oc_channel_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_i = '0;
    logic             cnt_en_i = 1'b1;
    logic             dir_down_i = 1'b0;
    logic             upd_i = 1'b0;
    logic             ctl_we_i = 1'b0;
    logic [15:0]      ctl_wdata_i = '0;
    logic             cmp_we_i = 1'b0;
    logic [CNT_W-1:0] cmp_wdata_i = '0;
    logic             ext_clr_i = 1'b0;
    logic             oc_ref_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    oc_channel #(.CNT_W(CNT_W), .HI_HALF(1'b0), .SLOW_EXTRA(2)) u_dut (
        .clk, .rst_n, .cnt_i, .cnt_en_i, .dir_down_i, .upd_i,
        .ctl_we_i, .ctl_wdata_i, .cmp_we_i, .cmp_wdata_i, .ext_clr_i, .oc_ref_o
    );

    // Lower-half encoding: bit7 clear en, 6:4 behaviour, 3 preload, 2 fast, 1:0 select.
    function automatic logic [15:0] lo(input bit clr, input int mode, input bit pre,
                                       input bit fast, input int sel);
        return {8'h00, clr, mode[2:0], pre, fast, sel[1:0]};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        repeat (4) tick();
    endtask

    task automatic check(input logic exp, input string tag);
        n_chk++;
        if (oc_ref_o !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, oc_ref_o, exp);
        end
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_we_i = 1'b1; ctl_wdata_i = v;
        tick();
        ctl_we_i = 1'b0;
    endtask

    task automatic wr_cmp(input logic [CNT_W-1:0] v);
        cmp_we_i = 1'b1; cmp_wdata_i = v;
        tick();
        cmp_we_i = 1'b0;
    endtask

    task automatic t_reset();
        check(1'b0, "R1 reset level");
        settle();
        check(1'b0, "R1 frozen after reset");
    endtask

    task automatic t_fields();
        wr_ctl(16'h5000);              // behaviour 5 in the other half
        settle();
        check(1'b0, "R2 other half ignored");
        wr_ctl(lo(0, 5, 0, 0, 0));
        settle();
        check(1'b1, "R2 lower half decoded");
    endtask

    task automatic t_match();
        cnt_i = 0;
        wr_ctl(lo(0, 4, 0, 1, 0)); settle();
        wr_cmp(16'd10);
        wr_ctl(lo(0, 1, 0, 1, 0)); settle();
        cnt_en_i = 1'b0; cnt_i = 10; tick(); cnt_i = 11; tick();
        check(1'b0, "R3 no match without count enable");
        cnt_en_i = 1'b1; cnt_i = 10; tick();
        check(1'b1, "R3 set on match");
        cnt_i = 11; settle();
        wr_ctl(lo(0, 2, 0, 1, 0));
        cnt_i = 10; tick();
        check(1'b0, "R3 clear on match");
        cnt_i = 0;
    endtask

    task automatic t_toggle();
        wr_cmp(16'd6);
        wr_ctl(lo(0, 4, 0, 1, 0)); settle();
        wr_ctl(lo(0, 3, 0, 1, 0)); settle();
        cnt_i = 6; tick(); cnt_i = 7; tick();
        check(1'b1, "R4 first toggle");
        cnt_en_i = 1'b0; cnt_i = 6; tick(); cnt_i = 7; tick();
        cnt_en_i = 1'b1;
        check(1'b1, "R4 disabled count does not toggle");
        cnt_i = 6; tick(); cnt_i = 7; tick();
        check(1'b0, "R4 second toggle");
        cnt_i = 0;
    endtask

    task automatic t_force_frozen();
        wr_ctl(lo(0, 5, 0, 1, 0)); settle();
        check(1'b1, "R5 force high");
        wr_ctl(lo(0, 0, 0, 1, 0));
        cnt_i = 6; settle(); cnt_i = 0;
        check(1'b1, "R5 frozen holds high through match");
        wr_ctl(lo(0, 4, 0, 1, 0)); settle();
        check(1'b0, "R5 force low");
    endtask

    task automatic t_pwm(input int mode, input string tag);
        logic inv;
        inv = (mode == 7);
        wr_cmp(16'd8);
        wr_ctl(lo(0, mode, 0, 1, 0));
        dir_down_i = 1'b0;
        cnt_i = 3;  settle(); check(1'b1 ^ inv, {tag, " up below"});
        cnt_i = 8;  settle(); check(1'b0 ^ inv, {tag, " up equal"});
        cnt_i = 12; settle(); check(1'b0 ^ inv, {tag, " up above"});
        dir_down_i = 1'b1;
        cnt_i = 12; settle(); check(1'b0 ^ inv, {tag, " down above"});
        cnt_i = 8;  settle(); check(1'b1 ^ inv, {tag, " down equal"});
        cnt_i = 3;  settle(); check(1'b1 ^ inv, {tag, " down below"});
        dir_down_i = 1'b0; cnt_i = 0;
    endtask

    task automatic t_preload();
        wr_ctl(lo(0, 6, 0, 1, 0));
        wr_cmp(16'd8);
        cnt_i = 10; settle();
        check(1'b0, "R8 base compare");
        wr_ctl(lo(0, 6, 1, 1, 0));
        wr_cmp(16'd20); settle();
        check(1'b0, "R8 preload write held back");
        upd_i = 1'b1; tick(); upd_i = 1'b0; settle();
        check(1'b1, "R8 copied on update");
        wr_ctl(lo(0, 6, 0, 1, 0));
        wr_cmp(16'd5); settle();
        check(1'b0, "R8 direct write");
        cnt_i = 0;
    endtask

    task automatic t_latency();
        wr_cmp(16'd10);
        wr_ctl(lo(0, 4, 0, 1, 0)); settle();
        wr_ctl(lo(0, 1, 0, 1, 0)); settle();
        cnt_i = 10; tick();
        check(1'b1, "R9 fast path one edge");
        cnt_i = 11;
        wr_ctl(lo(0, 4, 0, 0, 0)); settle();
        wr_ctl(lo(0, 1, 0, 0, 0)); settle();
        cnt_i = 10; tick();
        check(1'b0, "R9 slow path edge 1");
        cnt_i = 11; tick();
        check(1'b0, "R9 slow path edge 2");
        tick();
        check(1'b1, "R9 slow path edge 3");
        cnt_i = 0;
    endtask

    task automatic t_clear();
        wr_ctl(lo(1, 5, 0, 1, 0)); settle();
        check(1'b1, "R10 high before clear");
        ext_clr_i = 1'b1; tick(); ext_clr_i = 1'b0;
        check(1'b0, "R10 clear pulls low");
        settle();
        check(1'b0, "R10 held low until update");
        upd_i = 1'b1; tick(); upd_i = 1'b0; settle();
        check(1'b1, "R10 released by update");
        wr_ctl(lo(0, 5, 0, 1, 0));
        ext_clr_i = 1'b1; tick(); tick(); ext_clr_i = 1'b0;
        check(1'b1, "R10 clear ignored when disabled");
    endtask

    task automatic t_select();
        wr_ctl(lo(0, 5, 0, 1, 1)); settle();
        check(1'b0, "R11 select 1 holds low");
        wr_ctl(lo(0, 5, 0, 1, 3)); settle();
        check(1'b0, "R11 select 3 holds low");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_fields();
        t_match();
        t_toggle();
        t_force_frozen();
        t_pwm(6, "R6 pwm code 6");
        t_pwm(7, "R7 pwm code 7");
        t_preload();
        t_latency();
        t_clear();
        t_select();
        done = 1'b1;
        finish_run();
    end
endmodule